// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the host-facing half of a 4096-byte serial EEPROM. A fast system clock oversamples the four serial pins: serial clock, active-low select, data in and active-low pause. The block rebuilds the serial bit stream from those samples. Data in is taken on rising serial clock edges, and the data-out bit changes on falling edges, so hosts that idle the clock low and hosts that idle it high both work.

Each select frame begins with an 8-bit command. Some commands are followed by a 16-bit address, of which the block keeps the low 12 bits, and then by data bytes. The block does not store anything itself. It turns each frame into one-cycle requests to a storage back end:
- fetch a byte, with the byte returned one cycle after the strobe;
- store a byte;
- write the status byte;
- set or clear the write-enable latch.

It shifts fetched bytes and the status byte back to the host most significant bit first, and it drives an enable for an external tri-state buffer on the data-out pin.

A read continues for as long as the host keeps clocking, and the read address wraps from the top of the array back to zero. An unknown command locks the frame out until select is raised and lowered again. Pulling the pause pin low freezes the transfer at its current bit, and the transfer resumes from that bit when the pin is released.

Top module: `spi_ee_front`

## Requirements
- R1: Data in is captured on rising serial clock edges and the data-out bit changes on falling edges, so a read works with the clock idling low (mode 0) and with the clock idling high (mode 3).
- R2: The first byte of a frame is the command. 0x06 gives one `wel_set` pulse, 0x04 gives one `wel_clr` pulse, and at most one request strobe is active in any cycle.
- R3: Command 0x03 is followed by two address bytes, first byte first. Only the low 4 bits of the first byte and all of the second byte form the 12-bit address. Data then returns MSB first with `spi_so_oe` high.
- R4: During a read, each completed byte moves the fetch address up by one, and address 0xFFF is followed by 0x000.
- R5: Command 0x05 returns 0xFF for every byte while `wr_busy` is high, and returns `stat_rdata` MSB first while it is low.
- R6: Command 0x02 is followed by an address in the same format as R3. Each data byte then gives one `mem_wr` strobe. The first byte goes to the given address, and each later byte goes to the next address within the same 32-byte page (the low 5 bits wrap and the upper 7 bits stay fixed).
- R7: Command 0x01 takes its next byte as a status write and gives one `stat_wr` pulse carrying that byte.
- R8: After any other command byte, no request is issued and `spi_so_oe` stays low for the rest of the frame. The next frame decodes normally.
- R9: While select is high, `spi_so_oe` is low and no request is issued. Raising select in the middle of a byte discards that partial byte.
- R10: If the pause pin goes low while the serial clock is low, `spi_so_oe` drops and serial clock and data-in changes are ignored. When the pin goes high again, the transfer resumes at the same bit.
- R11: After reset, `spi_so_oe` is low and no request strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_si | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Active-low pause |
| spi_so | output | 1 | Serial data bit toward the host |
| spi_so_oe | output | 1 | Enable for the data-out tri-state buffer |
| mem_addr | output | 12 | Array address for fetch and store |
| mem_rd | output | 1 | Fetch strobe |
| mem_rdata | input | 8 | Fetched byte, valid one cycle after `mem_rd` |
| mem_wr | output | 1 | Store strobe |
| mem_wdata | output | 8 | Byte to store |
| stat_wr | output | 1 | Status write strobe |
| stat_wdata | output | 8 | New status byte |
| stat_rdata | input | 8 | Current status byte from the back end |
| wr_busy | input | 1 | Back end is in an internal write cycle |
| wel_set | output | 1 | Set the write-enable latch |
| wel_clr | output | 1 | Clear the write-enable latch |

## Verification
Reads are tried with the clock idling low and with it idling high, so a slip in edge selection shows up as shifted bits. A read that starts just below the top of the array shows the wrap, and a store that starts near the end of a page shows that the page wraps without carrying into the upper address bits. A read back of those stored bytes shows they landed where they should. A frame with an unknown command that is followed by a valid-looking read must produce nothing, a frame cut off after a few bits must not misalign the next command, and a pause held mid-byte with clock and data toggling must leave the returned byte intact.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   // Command codes; the values are fixed by the serial protocol.
   localparam logic [7:0] CMD_STAT_WR = 8'h01;
   localparam logic [7:0] CMD_STORE   = 8'h02;
   localparam logic [7:0] CMD_FETCH   = 8'h03;
   localparam logic [7:0] CMD_WEL_CLR = 8'h04;
   localparam logic [7:0] CMD_STAT_RD = 8'h05;
   localparam logic [7:0] CMD_WEL_SET = 8'h06;

   typedef enum logic [3:0] {
      PH_CMD,
      PH_ADR_HI,
      PH_ADR_LO,
      PH_STORE,
      PH_FETCH,
      PH_STAT_OUT,
      PH_STAT_IN,
      PH_QUIET,
      PH_LOCKED
   } phase_e;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
   parameter int         N       = 4,
   parameter int         STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_ee_sync needs at least two stages");
   end

   logic [N-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/spi_ee_rx.sv
module spi_ee_rx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_s,
   input  logic       cs_n_s,
   input  logic       si_s,
   input  logic       hold_n_s,
   output logic       paused,
   output logic       shift_fall,
   output logic       byte_done,
   output logic [7:0] byte_val
);

   logic       sck_q;
   logic [2:0] bit_cnt;
   logic [6:0] shreg;
   logic       act_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   // The pause state may only change while the serial clock is low.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      paused <= 1'b0;
      else if (cs_n_s) paused <= 1'b0;
      else if (!sck_s) paused <= !hold_n_s;
   end

   assign act_rise   = sck_s & ~sck_q & ~cs_n_s & ~paused;
   assign shift_fall = ~sck_s & sck_q & ~cs_n_s & ~paused;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         shreg     <= '0;
         byte_done <= 1'b0;
         byte_val  <= '0;
      end else if (cs_n_s) begin
         bit_cnt   <= '0;
         byte_done <= 1'b0;
      end else if (act_rise) begin
         shreg     <= {shreg[5:0], si_s};
         bit_cnt   <= bit_cnt + 3'd1;
         byte_done <= (bit_cnt == 3'd7);
         byte_val  <= {shreg, si_s};
      end else begin
         byte_done <= 1'b0;
      end
   end

   // R10: a paused frame keeps its bit position
   p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && !cs_n_s) |=> (cs_n_s || $stable(bit_cnt)));

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int PAGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              paused,
   input  logic              shift_fall,
   input  logic              byte_done,
   input  logic [7:0]        byte_val,
   input  logic [7:0]        mem_rdata,
   input  logic [7:0]        stat_rdata,
   input  logic              wr_busy,
   output logic              so,
   output logic              so_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   output logic              stat_wr,
   output logic [7:0]        stat_wdata,
   output logic              wel_set,
   output logic              wel_clr
);

   localparam int HI_W = ADDR_W - 8;

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
      $error("spi_ee_ctrl: ADDR_W must lie in 9..16");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_pw
      $error("spi_ee_ctrl: PAGE_W must lie in 1..ADDR_W-1");
   end

   phase_e            phase;
   logic              is_fetch;
   logic              wr_seen;
   logic              load_pend;
   logic [7:0]        txsh;
   logic [ADDR_W-1:0] addr;

   function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
      logic [PAGE_W-1:0] lo;
      lo = a[PAGE_W-1:0] + PAGE_W'(1);
      return {a[ADDR_W-1:PAGE_W], lo};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_CMD;
         is_fetch   <= 1'b0;
         wr_seen    <= 1'b0;
         load_pend  <= 1'b0;
         txsh       <= '1;
         so         <= 1'b0;
         addr       <= '0;
         mem_rd     <= 1'b0;
         mem_wr     <= 1'b0;
         mem_wdata  <= '0;
         stat_wr    <= 1'b0;
         stat_wdata <= '0;
         wel_set    <= 1'b0;
         wel_clr    <= 1'b0;
      end else begin
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         stat_wr   <= 1'b0;
         wel_set   <= 1'b0;
         wel_clr   <= 1'b0;
         load_pend <= mem_rd;
         if (cs_n_s) begin
            phase     <= PH_CMD;
            load_pend <= 1'b0;
         end else begin
            if (shift_fall) begin
               so   <= txsh[7];
               txsh <= {txsh[6:0], 1'b1};
            end
            if (load_pend) txsh <= mem_rdata;
            if (byte_done) begin
               unique case (phase)
                  PH_CMD: begin
                     case (byte_val)
                        CMD_WEL_SET: begin wel_set <= 1'b1; phase <= PH_QUIET; end
                        CMD_WEL_CLR: begin wel_clr <= 1'b1; phase <= PH_QUIET; end
                        CMD_STAT_RD: begin
                           txsh  <= wr_busy ? 8'hFF : stat_rdata;
                           phase <= PH_STAT_OUT;
                        end
                        CMD_STAT_WR: phase <= PH_STAT_IN;
                        CMD_FETCH:   begin is_fetch <= 1'b1; phase <= PH_ADR_HI; end
                        CMD_STORE:   begin is_fetch <= 1'b0; phase <= PH_ADR_HI; end
                        default:     phase <= PH_LOCKED;
                     endcase
                  end
                  PH_ADR_HI: begin
                     addr[ADDR_W-1:8] <= byte_val[HI_W-1:0];
                     phase            <= PH_ADR_LO;
                  end
                  PH_ADR_LO: begin
                     addr[7:0] <= byte_val;
                     wr_seen   <= 1'b0;
                     if (is_fetch) begin
                        mem_rd <= 1'b1;
                        phase  <= PH_FETCH;
                     end else begin
                        phase  <= PH_STORE;
                     end
                  end
                  PH_FETCH: begin
                     addr   <= addr + ADDR_W'(1);
                     mem_rd <= 1'b1;
                  end
                  PH_STORE: begin
                     if (wr_seen) addr <= page_next(addr);
                     wr_seen   <= 1'b1;
                     mem_wr    <= 1'b1;
                     mem_wdata <= byte_val;
                  end
                  PH_STAT_IN: begin
                     stat_wr    <= 1'b1;
                     stat_wdata <= byte_val;
                     phase      <= PH_QUIET;
                  end
                  PH_STAT_OUT: txsh <= wr_busy ? 8'hFF : stat_rdata;
                  default: ;
               endcase
            end
         end
      end
   end

   assign mem_addr = addr;
   assign so_oe    = !cs_n_s && !paused &&
                     (phase == PH_FETCH || phase == PH_STAT_OUT);

   // R2: never two requests in one cycle
   p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, stat_wr, wel_set, wel_clr}));

   // R4: each further fetched byte reads the next address
   p_fetch_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase == PH_FETCH && !cs_n_s)
      |=> (mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(1)));

   // R6: stores never leave their page
   p_page_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase == PH_STORE && !cs_n_s)
      |=> (mem_wr && mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));

   // R8: a locked frame stays silent
   p_locked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOCKED) |-> (!so_oe && !mem_rd && !mem_wr && !stat_wr));

   // R9: no request follows a deselected cycle
   p_idle_noreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (!mem_rd && !mem_wr && !stat_wr && !wel_set && !wel_clr));

endmodule

// File: rtl/spi_ee_front.sv
module spi_ee_front #(
   parameter int ADDR_W      = 12,
   parameter int PAGE_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_si,
   input  logic              spi_hold_n,
   output logic              spi_so,
   output logic              spi_so_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [7:0]        mem_rdata,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   output logic              stat_wr,
   output logic [7:0]        stat_wdata,
   input  logic [7:0]        stat_rdata,
   input  logic              wr_busy,
   output logic              wel_set,
   output logic              wel_clr
);

   // pin order inside the synchroniser: {pause, data in, select, clock}
   localparam logic [3:0] PIN_RST = 4'b1010;

   logic [3:0] pins_s;
   logic       paused;
   logic       shift_fall;
   logic       byte_done;
   logic [7:0] byte_val;

   spi_ee_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_hold_n, spi_si, spi_cs_n, spi_sck}),
      .dout (pins_s)
   );

   spi_ee_rx u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (pins_s[0]),
      .cs_n_s    (pins_s[1]),
      .si_s      (pins_s[2]),
      .hold_n_s  (pins_s[3]),
      .paused    (paused),
      .shift_fall(shift_fall),
      .byte_done (byte_done),
      .byte_val  (byte_val)
   );

   spi_ee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (pins_s[1]),
      .paused    (paused),
      .shift_fall(shift_fall),
      .byte_done (byte_done),
      .byte_val  (byte_val),
      .mem_rdata (mem_rdata),
      .stat_rdata(stat_rdata),
      .wr_busy   (wr_busy),
      .so        (spi_so),
      .so_oe     (spi_so_oe),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .stat_wr   (stat_wr),
      .stat_wdata(stat_wdata),
      .wel_set   (wel_set),
      .wel_clr   (wel_clr)
   );

   // R11: quiet out of reset
   p_reset_quiet_r11: assert property (@(posedge clk)
      $rose(rst_n) |-> (!spi_so_oe && !mem_rd && !mem_wr && !stat_wr));

endmodule

// File: tb/sim_spi_ee_front.sv
module sim_spi_ee_front;

   localparam int CLK_P = 10;
   localparam int HALF  = 8;
   localparam int DEPTH = 4096;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
   logic so, so_oe, mem_rd, mem_wr, stat_wr, wel_set, wel_clr;
   logic [11:0] mem_addr;
   logic [7:0]  mem_wdata, stat_wdata;
   logic [7:0]  mem_rdata = 8'h00;
   logic [7:0]  stat_rdata = 8'h8C;
   logic        wr_busy = 1'b0;

   spi_ee_front u0 (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
      .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
      .wr_busy(wr_busy), .wel_set(wel_set), .wel_clr(wel_clr)
   );

   always #(CLK_P/2) clk = ~clk;

   // back end model and an independent reference image
   logic [7:0] mem     [DEPTH];
   logic [7:0] ref_mem [DEPTH];
   initial for (int i = 0; i < DEPTH; i++) begin
      mem[i]     = 8'((i * 29) + (i >> 5));
      ref_mem[i] = 8'((i * 29) + (i >> 5));
   end

   int n_rd = 0, n_wr = 0, n_sw = 0, n_set = 0, n_clr = 0;
   logic [11:0] wr_a [$];
   logic [7:0]  wr_d [$];
   logic [7:0]  sw_d = 8'h00;

   always @(posedge clk) begin
      if (mem_rd) begin mem_rdata <= mem[mem_addr]; n_rd++; end
      if (mem_wr) begin
         mem[mem_addr] <= mem_wdata;
         n_wr++; wr_a.push_back(mem_addr); wr_d.push_back(mem_wdata);
      end
      if (stat_wr) begin n_sw++; sw_d <= stat_wdata; end
      if (wel_set) n_set++;
      if (wel_clr) n_clr++;
   end

   int passed = 0, total = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (ok) passed++;
      else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
   endtask

   // R9 per clock: data out stays disabled once select has been high a while
   int cs_hi = 0;
   always @(negedge clk) begin
      if (cs_n) cs_hi++; else cs_hi = 0;
      if (rst_n && cs_hi > 4) chk(!so_oe, "R9", "oe while deselected", int'(so_oe), 0);
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   logic [7:0] txb [16];
   logic [7:0] rxb [16];
   bit         oeb [16];
   int         hold_bit = -1;

   task automatic do_hold();
      wait_cyc(HALF);
      hold_n = 1'b0;
      wait_cyc(6);
      chk(!so_oe, "R10", "oe during pause", int'(so_oe), 0);
      si = ~si; sck = 1'b1; wait_cyc(4);
      sck = 1'b0; wait_cyc(4);
      si = ~si; hold_n = 1'b1;
      wait_cyc(6);
   endtask

   task automatic run_frame(input int n, input bit m3);
      int bitno = 0;
      sck = m3; wait_cyc(HALF);
      cs_n = 1'b0; wait_cyc(HALF);
      for (int k = 0; k < n; k++) begin
         oeb[k] = 1'b1;
         for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = txb[k][i];
            if (bitno == hold_bit) do_hold();
            wait_cyc(HALF);
            rxb[k][i] = so;
            if (!so_oe) oeb[k] = 1'b0;
            sck = 1'b1; wait_cyc(HALF);
            bitno++;
         end
      end
      if (!m3) sck = 1'b0;
      wait_cyc(HALF);
      cs_n = 1'b1;
      wait_cyc(2 * HALF);
   endtask

   task automatic read_chk(input logic [11:0] a, input int n, input bit m3, input string req);
      txb[0] = 8'h03; txb[1] = {4'hA, a[11:8]}; txb[2] = a[7:0];
      for (int k = 0; k < n; k++) txb[3+k] = 8'h00;
      run_frame(3 + n, m3);
      for (int k = 0; k < n; k++) begin
         logic [11:0] ea;
         ea = a + 12'(k);
         chk(rxb[3+k] == ref_mem[ea], req, "read byte", int'(rxb[3+k]), int'(ref_mem[ea]));
         chk(oeb[3+k], req, "oe during read byte", int'(oeb[3+k]), 1);
      end
   endtask

   initial begin
      int s_rd, s_wr, s_sw, s_set, s_clr;
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(10);
      // R11: reset state
      chk(!so_oe, "R11", "oe after reset", int'(so_oe), 0);
      chk(n_rd + n_wr + n_sw + n_set + n_clr == 0, "R11", "requests after reset",
          n_rd + n_wr + n_sw + n_set + n_clr, 0);

      // R1, R3: read in mode 0 with junk upper address bits
      read_chk(12'h123, 4, 1'b0, "R3");
      // R4: wrap at the top of the array
      read_chk(12'hFFE, 4, 1'b0, "R4");
      // R1: read in mode 3
      read_chk(12'h456, 2, 1'b1, "R1");

      // R2: latch commands
      txb[0] = 8'h06; run_frame(1, 1'b0);
      chk(n_set == 1 && n_clr == 0, "R2", "set pulses", n_set, 1);
      txb[0] = 8'h04; run_frame(1, 1'b1);
      chk(n_clr == 1 && n_set == 1, "R2", "clear pulses", n_clr, 1);

      // R5: status read while busy and while idle
      wr_busy = 1'b1;
      txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00; run_frame(3, 1'b0);
      chk(rxb[1] == 8'hFF && rxb[2] == 8'hFF, "R5", "busy status", int'(rxb[1]), 8'hFF);
      wr_busy = 1'b0;
      run_frame(3, 1'b0);
      chk(rxb[1] == 8'h8C, "R5", "status byte 1", int'(rxb[1]), 8'h8C);
      chk(rxb[2] == 8'h8C && oeb[2], "R5", "status byte 2", int'(rxb[2]), 8'h8C);

      // R6: store with page wrap
      s_wr = n_wr;
      txb[0] = 8'h02; txb[1] = 8'h50; txb[2] = 8'h3E;
      txb[3] = 8'h11; txb[4] = 8'h22; txb[5] = 8'h33;
      run_frame(6, 1'b0);
      chk(n_wr - s_wr == 3, "R6", "store count", n_wr - s_wr, 3);
      chk(wr_a.size() == 3 && wr_a[0] == 12'h03E && wr_d[0] == 8'h11, "R6", "first store",
          int'(wr_a[0]), 12'h03E);
      chk(wr_a[1] == 12'h03F && wr_d[1] == 8'h22, "R6", "second store", int'(wr_a[1]), 12'h03F);
      chk(wr_a[2] == 12'h020 && wr_d[2] == 8'h33, "R6", "wrapped store", int'(wr_a[2]), 12'h020);
      ref_mem[12'h03E] = 8'h11; ref_mem[12'h03F] = 8'h22; ref_mem[12'h020] = 8'h33;
      read_chk(12'h03E, 2, 1'b0, "R6");
      read_chk(12'h020, 1, 1'b1, "R6");

      // R7: status write
      s_sw = n_sw;
      txb[0] = 8'h01; txb[1] = 8'h0C; run_frame(2, 1'b0);
      chk(n_sw - s_sw == 1, "R7", "status write count", n_sw - s_sw, 1);
      chk(sw_d == 8'h0C, "R7", "status write value", int'(sw_d), 8'h0C);

      // R8: unknown command locks the frame
      s_rd = n_rd; s_wr = n_wr; s_sw = n_sw; s_set = n_set; s_clr = n_clr;
      txb[0] = 8'h55; txb[1] = 8'h03; txb[2] = 8'h00; txb[3] = 8'h00;
      txb[4] = 8'hFF; txb[5] = 8'hFF;
      run_frame(6, 1'b0);
      chk(!(oeb[1] | oeb[2] | oeb[3] | oeb[4] | oeb[5]), "R8", "oe in locked frame",
          int'(oeb[4]), 0);
      chk(n_rd == s_rd && n_wr == s_wr && n_sw == s_sw && n_set == s_set && n_clr == s_clr,
          "R8", "requests in locked frame", n_rd - s_rd, 0);
      read_chk(12'h010, 1, 1'b0, "R8");

      // R9: aborted partial byte is discarded
      cs_n = 1'b0; wait_cyc(HALF);
      for (int i = 0; i < 5; i++) begin
         sck = 1'b0; si = 1'b1; wait_cyc(HALF);
         sck = 1'b1; wait_cyc(HALF);
      end
      sck = 1'b0; wait_cyc(HALF);
      cs_n = 1'b1; wait_cyc(2 * HALF);
      read_chk(12'h200, 2, 1'b0, "R9");

      // R10: pause in the middle of a data byte
      hold_bit = 27;
      read_chk(12'h777, 2, 1'b0, "R10");
      hold_bit = -1;

      done = 1'b1;
      $display("%0d/%0d checks passed", passed, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", passed, total);
         $finish;
      end
   end

endmodule